// File: doc/BRIEF.md
# Burst-of-Four Late-Write Memory Port

This block is a word-addressed storage array fed by a double-data-rate write port that takes bursts of four. A command is sampled on a rising edge of the system clock. It is made of an active-low load strobe, a read/write select and a word address whose two low bits give the starting position inside an aligned group of four words. The write data arrives late: the four beats come on the two clock edges that follow the command. Each clock cycle carries two beats, one on the rising-phase lane and one on the falling-phase lane. Each beat has its own active-low enables, one for each 9-bit byte lane.

Read commands and deselect cycles write nothing. Any data present on the beat lanes while no write is pending is discarded. Once a burst has been accepted it always completes, even if a deselect follows it at once. A registered read-back port returns the contents of any word one cycle after its address is presented. Word width is set by a parameter: 36 bits with four lanes, or 18 bits with two lanes.

Top module: `burst4_write_port`

## Requirements
- R1: After reset, `rb_data` is zero and every word of the array reads back as zero.
- R2: A write command is taken on a rising clock edge when `ld_n`=0 and `rw_sel`=0. Its first two beats (`d_rise`, then `d_fall`) are stored at the next edge, and its last two beats are stored at the edge after that.
- R3: The burst keeps address bits above bit 1 fixed. The low two bits step through start, start+1, start+2 and start+3, wrapping modulo 4. The rising lane carries the even steps and the falling lane the odd steps.
- R4: Byte lane i covers data bits 9i to 9i+8. Its enable (`bw_n_rise[i]` or `bw_n_fall[i]`) is active low. A lane whose enable is 1 keeps its previous contents.
- R5: A cycle with `ld_n`=1 (deselect) or with `ld_n`=0 and `rw_sel`=1 (read) starts no write. Beat data present while no burst is pending changes no word.
- R6: A command presented in the cycle right after an accepted write command is ignored. A command presented two cycles after it is accepted, so bursts can follow each other with no gap on the beat lanes.
- R7: An accepted burst writes all four of its beats, whatever the command inputs do during its data cycles.
- R8: `rb_data` is registered. It shows the word at `rb_addr` as it stood before the edge, so a beat stored at that same edge becomes visible one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; each cycle carries two beats |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Command load strobe, active low |
| rw_sel | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | ADDR_W | Word address; the two low bits give the burst start |
| d_rise | input | DATA_W | Rising-phase beat data |
| bw_n_rise | input | DATA_W/9 | Rising-phase byte-lane enables, active low |
| d_fall | input | DATA_W | Falling-phase beat data |
| bw_n_fall | input | DATA_W/9 | Falling-phase byte-lane enables, active low |
| rb_addr | input | ADDR_W | Read-back word address |
| rb_data | output | DATA_W | Registered read-back data |

## Verification
Two events can fall in the same cycle. A new write command can be sampled at the same edge that stores the last two beats of the previous burst. A read-back can also target a word that is being written at that edge. The bench provokes the first with bursts issued every second cycle, each with a stray command placed in the cycle between. It provokes the second by pointing `rb_addr` at a beat address during the cycle that beat is stored. A behavioural model holds the pending beats in a queue and takes its read-back value before it applies the writes. Its value is compared with `rb_data` on every clock.

// File: rtl/b4wp_pkg.sv
package b4wp_pkg;
  localparam int LANE_W = 9;
  localparam int BURST_LEN = 4;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;
endpackage

// File: rtl/b4wp_cmd.sv
module b4wp_cmd
  import b4wp_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_n,
  input  logic              rw_sel,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              beat_vld,
  output logic [ADDR_W-1:0] beat_addr_r,
  output logic [ADDR_W-1:0] beat_addr_f
);
  phase_e            phase_q, phase_d;
  logic [ADDR_W-1:0] base_q;
  logic              accept;
  logic [1:0]        step;

  always_comb begin
    accept = (phase_q != PH_FIRST) && !ld_n && !rw_sel;
    if (accept)                  phase_d = PH_FIRST;
    else if (phase_q == PH_FIRST) phase_d = PH_SECOND;
    else                         phase_d = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      base_q <= '0;
    else if (accept) base_q <= cmd_addr;
  end

  always_comb begin
    step        = (phase_q == PH_SECOND) ? 2'd2 : 2'd0;
    beat_vld    = (phase_q != PH_IDLE);
    beat_addr_r = {base_q[ADDR_W-1:2], base_q[1:0] + step};
    beat_addr_f = {base_q[ADDR_W-1:2], base_q[1:0] + step + 2'd1};
  end

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != 2'd3) else $error("phase"); // R6
  AST_WRITE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_FIRST && !ld_n && !rw_sel) |=> phase_q == PH_FIRST) else $error("take"); // R2
  AST_MID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_FIRST |=> (phase_q == PH_SECOND && $stable(base_q))) else $error("mid"); // R7
  AST_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_FIRST && (ld_n || rw_sel)) |=> phase_q == PH_IDLE) else $error("nostart"); // R5
endmodule

// File: rtl/b4wp_array.sv
module b4wp_array
  import b4wp_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6,
  localparam int LANES = DATA_W / LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr_r,
  input  logic [DATA_W-1:0] wr_data_r,
  input  logic [LANES-1:0]  wr_lane_r,
  input  logic [ADDR_W-1:0] wr_addr_f,
  input  logic [DATA_W-1:0] wr_data_f,
  input  logic [LANES-1:0]  wr_lane_f,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rb_q;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic hit_r, hit_f;
    always_comb begin
      hit_r = wr_en && (wr_addr_r == ADDR_W'(w));
      hit_f = wr_en && (wr_addr_f == ADDR_W'(w));
    end
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mem_q[w][l*LANE_W +: LANE_W] <= '0;
        else if (hit_r && wr_lane_r[l])
          mem_q[w][l*LANE_W +: LANE_W] <= wr_data_r[l*LANE_W +: LANE_W];
        else if (hit_f && wr_lane_f[l])
          mem_q[w][l*LANE_W +: LANE_W] <= wr_data_f[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rb_q <= '0;
    else        rb_q <= mem_q[rb_addr];
  end
  assign rb_data = rb_q;

  AST_BEATS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr_r != wr_addr_f) else $error("distinct"); // R3
  AST_FALL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr_f[1:0] == wr_addr_r[1:0] + 2'd1 &&
               wr_addr_f[ADDR_W-1:2] == wr_addr_r[ADDR_W-1:2])) else $error("order"); // R3
  AST_READ_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(rb_addr) && !wr_en && $past(!wr_en) |=> $stable(rb_data)) else $error("rb"); // R8
endmodule

// File: rtl/burst4_write_port.sv
module burst4_write_port
  import b4wp_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_n,
  input  logic              rw_sel,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] d_rise,
  input  logic [LANES-1:0]  bw_n_rise,
  input  logic [DATA_W-1:0] d_fall,
  input  logic [LANES-1:0]  bw_n_fall,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data
);
  logic              beat_vld;
  logic [ADDR_W-1:0] beat_addr_r, beat_addr_f;
  logic [LANES-1:0]  lane_en_r, lane_en_f;

  always_comb begin
    lane_en_r = ~bw_n_rise;
    lane_en_f = ~bw_n_fall;
  end

  b4wp_cmd #(.ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw_sel(rw_sel),
    .cmd_addr(cmd_addr), .beat_vld(beat_vld),
    .beat_addr_r(beat_addr_r), .beat_addr_f(beat_addr_f)
  );

  b4wp_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(beat_vld),
    .wr_addr_r(beat_addr_r), .wr_data_r(d_rise), .wr_lane_r(lane_en_r),
    .wr_addr_f(beat_addr_f), .wr_data_f(d_fall), .wr_lane_f(lane_en_f),
    .rb_addr(rb_addr), .rb_data(rb_data)
  );

  AST_RESET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rb_data == '0) else $error("reset"); // R1
endmodule

// File: tb/burst4_write_port_test.sv
`timescale 1ns/1ps
module burst4_write_port_test;
  localparam int DW = 36;
  localparam int AW = 6;
  localparam int NL = 4;

  logic clk = 0, rst_n = 0;
  logic ld_n = 1, rw_sel = 0;
  logic [AW-1:0] cmd_addr = '0, rb_addr = '0;
  logic [DW-1:0] d_rise = '0, d_fall = '0;
  logic [NL-1:0] bw_n_rise = '1, bw_n_fall = '1;
  logic [DW-1:0] rb_data;

  int total = 0, bad = 0;
  bit done = 0, chk_en = 0;
  string cur_req = "R1";

  burst4_write_port uut (.*);

  always #2.5 clk = ~clk;

  logic [DW-1:0] model [64];
  logic [AW-1:0] pend_q [$];
  logic [DW-1:0] exp_rb;

  task automatic apply_beat(logic [AW-1:0] a, logic [DW-1:0] d, logic [NL-1:0] bn);
    for (int l = 0; l < NL; l++)
      if (!bn[l]) model[a][l*9 +: 9] = d[l*9 +: 9];
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) model[i] = '0;
      pend_q.delete();
      exp_rb = '0;
    end else begin
      bit take;
      take = (pend_q.size() != 4) && !ld_n && !rw_sel;
      exp_rb = model[rb_addr];
      if (pend_q.size() != 0) begin
        apply_beat(pend_q.pop_front(), d_rise, bw_n_rise);
        apply_beat(pend_q.pop_front(), d_fall, bw_n_fall);
      end
      if (take)
        for (int k = 0; k < 4; k++)
          pend_q.push_back({cmd_addr[AW-1:2], 2'(cmd_addr[1:0] + k)});
    end
  end

  always @(negedge clk) if (chk_en && !done) begin
    total++;
    if (rb_data !== exp_rb) begin
      bad++;
      $display("FAIL %s rb_addr=%0d actual=%h expected=%h", cur_req, $past(rb_addr), rb_data, exp_rb);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic cyc(logic l, logic rw, logic [AW-1:0] a,
                     logic [DW-1:0] dr, logic [NL-1:0] br,
                     logic [DW-1:0] df, logic [NL-1:0] bf, logic [AW-1:0] ra);
    @(negedge clk);
    ld_n = l; rw_sel = rw; cmd_addr = a;
    d_rise = dr; bw_n_rise = br; d_fall = df; bw_n_fall = bf; rb_addr = ra;
  endtask

  task automatic idle(logic [AW-1:0] ra);
    cyc(1, 0, '0, {DW{1'b1}}, '0, {DW{1'b1}}, '0, ra);
  endtask

  task automatic sweep(logic [AW-1:0] lo, int n);
    for (int i = 0; i < n; i++) idle(AW'(lo + i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (rb_data !== '0) begin
      bad++;
      $display("FAIL R1 reset actual=%h expected=0", rb_data);
    end
    rst_n = 1;
    chk_en = 1;
    cur_req = "R1"; sweep(0, 64);
    // R2 R3: write starting at offset 1 of group 4..7
    cur_req = "R2";
    cyc(0, 0, 6'd5, '0, '1, '0, '1, 0);
    cyc(1, 0, 0, 36'h1_1111_1111, '0, 36'h2_2222_2222, '0, 0);
    cyc(1, 0, 0, 36'h3_3333_3333, '0, 36'h4_4444_4444, '0, 0);
    cur_req = "R3"; sweep(4, 4);
    // R4 masked lanes over the same group
    cur_req = "R4";
    cyc(0, 0, 6'd4, '0, '1, '0, '1, 0);
    cyc(1, 0, 0, 36'hA_AAAA_AAAA, 4'b1010, 36'hB_BBBB_BBBB, 4'b0101, 0);
    cyc(1, 0, 0, 36'hC_CCCC_CCCC, 4'b1111, 36'hD_DDDD_DDDD, 4'b0000, 0);
    sweep(4, 4);
    // R5 deselect and read commands with live data
    cur_req = "R5";
    cyc(1, 0, 6'd8, 36'h5_5555_5555, '0, 36'h6_6666_6666, '0, 8);
    cyc(0, 1, 6'd8, 36'h7_7777_7777, '0, 36'h8_8888_8888, '0, 9);
    cyc(1, 1, 6'd8, 36'h9_9999_9999, '0, 36'hE_EEEE_EEEE, '0, 10);
    cyc(1, 0, 6'd8, 36'hF_0F0F_0F0F, '0, 36'h1_2345_6789, '0, 8);
    sweep(8, 4);
    // R6 back-to-back bursts, stray command between each
    cur_req = "R6";
    for (int b = 0; b < 3; b++) begin
      cyc(0, 0, AW'(16 + 4*b + b), 36'(b), '0, 36'(b+10), '0, 0);
      cyc(0, 0, 6'd40, 36'(100+b), '0, 36'(200+b), '0, 0);
    end
    cyc(1, 0, 0, 36'h3_0000_0003, '0, 36'h4_0000_0004, '0, 0);
    sweep(16, 12); sweep(40, 4);
    // R7 deselect during burst; R8 read-back of word written same edge
    cur_req = "R7";
    cyc(0, 0, 6'd50, '0, '1, '0, '1, 50);
    cyc(1, 1, 6'd3, 36'h7_0000_0001, '0, 36'h7_0000_0002, '0, 50);
    cur_req = "R8";
    cyc(0, 1, 6'd3, 36'h7_0000_0003, '0, 36'h7_0000_0004, '0, 48);
    cyc(1, 0, 0, '0, '1, '0, '1, 48);
    cur_req = "R7"; sweep(48, 4);
    // mixed random traffic covering R2 to R8
    cur_req = "R2-mix R4 R5 R6";
    for (int i = 0; i < 600; i++)
      cyc(($urandom % 3) == 0, ($urandom % 4) == 0, AW'($urandom),
          {$urandom, $urandom}, NL'($urandom), {$urandom, $urandom},
          NL'($urandom), AW'($urandom));
    cur_req = "R8"; sweep(0, 64);
    @(negedge clk);
    finish_run();
  end
endmodule